// File: doc/BRIEF.md
# Paged DMA Transfer and Write-Check Engine

This engine moves a stream of 16-bit drive words between a drive-side stream interface and byte-addressed memory. It runs in one of three operations: it reads memory and streams the words to the drive, it takes words from the drive and stores them in memory, or it compares drive words with memory contents (write-check). The caller supplies the starting virtual address, the current byte-count register value and a requested length. The engine clips the length to the space left in the 16-bit byte counter and then walks the transfer in chunks. A chunk never crosses a page boundary, and each chunk starts with its own translation request.

Inside a chunk the engine issues byte, word or longword memory accesses. The width is chosen once per chunk from the alignment of the physical address, the chunk length and the stream position. A transfer ends early on a failed translation, on a nonexistent-memory translation, or on the first write-check mismatch. At the end the engine gives a single done pulse, together with the number of bytes completed, the advanced address and byte-count values, and the error flags.

Top module: `pgdma_engine`

## Requirements
- R1: The transfer length is the smaller of `req_len` and 2^BC_W minus `bc_i`. A zero length finishes with `nbytes` = 0 and no translation request. `nbytes` never exceeds this length.
- R2: A translation of the virtual page of the current address (`xl_vpn`) is requested at the start of the transfer and again each time the address reaches a page boundary. `xl_req` holds with a stable page number until `xl_ack`. Each chunk ends at the page end or the transfer end, whichever is first.
- R3: `mem_size` encodes 0 = byte, 1 = word, 2 = longword. A chunk whose physical address and length are both multiples of 4, starting at an even stream position, uses longword accesses. Each longword carries two stream words, with the low half (bits 15:0) first.
- R4: A chunk with an odd physical address, an odd length or an odd starting stream position uses byte accesses. Any other non-longword chunk uses word accesses. Byte and word data sit right-justified on `mem_wdata`/`mem_rdata`. A byte at an even stream position is bits 7:0 of its stream word, and a byte at an odd position is bits 15:8.
- R5: With `op` = 0 (memory to drive), the stream words come out on `dout_data` in order. When a transfer of odd length completes, its final byte is sent in a last word whose upper byte is zero.
- R6: With `op` = 1 (drive to memory), the stream bytes are stored at their translated addresses and no other memory byte changes.
- R7: A translation answered with `xl_valid` = 0 stops the transfer and sets `err_inval`. A translation answered with `xl_nxm` = 1 stops it and sets `err_rdto`. In both cases `nbytes` counts the bytes done before that page.
- R8: With `op` = 2 (write-check), memory is read one byte at a time and compared with the stream byte. On the first mismatch the transfer stops and raises `err_wcl` for an even stream position or `err_wch` for an odd one. The mismatched byte is not counted.
- R9: At done, `va_o` is `va_i` plus `nbytes` modulo 2^VA_W, and `bc_o` is `bc_i` plus `nbytes` modulo 2^BC_W.
- R10: Each started transfer produces `done` high for exactly one cycle. `nbytes`, `va_o`, `bc_o` and the error flags are valid in that cycle, and the flags are cleared when the next transfer starts.
- R11: After reset, `done`, `mem_req`, `xl_req`, `dout_valid` and `din_ready` are low. `mem_req` holds with a stable address and size until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| op | input | 2 | 0 memory to drive, 1 drive to memory, 2 write-check |
| req_len | input | BC_W+1 | Requested byte count |
| va_i | input | VA_W | Starting virtual address |
| bc_i | input | BC_W | Byte-count register value at start |
| xl_req | output | 1 | Translation request |
| xl_vpn | output | VA_W-PB | Virtual page to translate |
| xl_ack | input | 1 | Translation answer strobe |
| xl_valid | input | 1 | Translation is valid |
| xl_nxm | input | 1 | Translated page is nonexistent memory |
| xl_pfn | input | PFN_W | Physical page number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_size | output | 2 | Access size (0 byte, 1 word, 2 longword) |
| mem_addr | output | PFN_W+PB | Physical byte address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, right-justified |
| din_data | input | 16 | Drive word into engine |
| din_valid | input | 1 | Drive word valid |
| din_ready | output | 1 | Engine accepts drive word |
| dout_data | output | 16 | Word to drive |
| dout_valid | output | 1 | Word to drive valid |
| dout_ready | input | 1 | Drive accepts word |
| done | output | 1 | One-cycle completion pulse |
| nbytes | output | BC_W+1 | Bytes completed |
| va_o | output | VA_W | Advanced virtual address |
| bc_o | output | BC_W | Advanced byte-count value |
| err_inval | output | 1 | Invalid translation stop |
| err_rdto | output | 1 | Nonexistent-memory stop |
| err_wcl | output | 1 | Write-check mismatch, even byte |
| err_wch | output | 1 | Write-check mismatch, odd byte |

## Verification
The bench builds the engine with PB = 4 (16-byte pages) and PFN_W = 8, keeping VA_W = 17 and BC_W = 16. The small pages make transfers of a few dozen bytes cross several page boundaries. A chunk can then start at an odd stream position, land on every access width, and hit a failing translation in the middle of a transfer. The full-width address and counter registers let short transfers reach the 17-bit address wrap and the 16-bit byte-count limit.

// File: rtl/pgdma_engine.sv
module pgdma_engine #(
  parameter int PB    = 9,
  parameter int VA_W  = 17,
  parameter int BC_W  = 16,
  parameter int PFN_W = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [BC_W:0]        req_len,
  input  logic [VA_W-1:0]      va_i,
  input  logic [BC_W-1:0]      bc_i,
  output logic                 xl_req,
  output logic [VA_W-PB-1:0]   xl_vpn,
  input  logic                 xl_ack,
  input  logic                 xl_valid,
  input  logic                 xl_nxm,
  input  logic [PFN_W-1:0]     xl_pfn,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [1:0]           mem_size,
  output logic [PFN_W+PB-1:0]  mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_ack,
  input  logic [31:0]          mem_rdata,
  input  logic [15:0]          din_data,
  input  logic                 din_valid,
  output logic                 din_ready,
  output logic [15:0]          dout_data,
  output logic                 dout_valid,
  input  logic                 dout_ready,
  output logic                 done,
  output logic [BC_W:0]        nbytes,
  output logic [VA_W-1:0]      va_o,
  output logic [BC_W-1:0]      bc_o,
  output logic                 err_inval,
  output logic                 err_rdto,
  output logic                 err_wcl,
  output logic                 err_wch
);
  localparam int PA_W = PFN_W + PB;
  localparam int CW   = BC_W + 1;
  localparam int LW   = PB + 1;
  localparam logic [1:0] SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_CK = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_XLAT, S_ACC, S_PULL, S_MEM, S_PUSH, S_NEXT, S_FIN} st_t;
  st_t st;

  logic [1:0]      opr, md;
  logic [CW-1:0]   len, cnt;
  logic [VA_W-1:0] va0;
  logic [BC_W-1:0] bc0;
  logic [LW-1:0]   left;
  logic [PA_W-1:0] pa;
  logic [31:0]     stg;
  logic            hw;

  wire [CW-1:0]   full    = {1'b1, {BC_W{1'b0}}};
  wire [CW-1:0]   avail   = full - {1'b0, bc_i};
  wire [CW-1:0]   len_n   = (req_len < avail) ? req_len : avail;
  wire [VA_W-1:0] cur_va  = va0 + VA_W'(cnt);
  wire [PB-1:0]   off     = cur_va[PB-1:0];
  wire [LW-1:0]   pg_left = {1'b1, {PB{1'b0}}} - {1'b0, off};
  wire [CW-1:0]   rem     = len - cnt;
  wire [LW-1:0]   clen    = (rem < CW'(pg_left)) ? LW'(rem) : pg_left;
  wire [1:0]      sel     = (opr == OP_CK || off[0] || clen[0] || cnt[0]) ? SZ_B :
                            (off[1] || clen[1]) ? SZ_W : SZ_L;
  wire [2:0]      asz     = (md == SZ_L) ? 3'd4 : (md == SZ_W) ? 3'd2 : 3'd1;
  wire [7:0]      sbyte   = cnt[0] ? stg[15:8] : stg[7:0];
  wire            miss    = mem_rdata[7:0] != sbyte;
  wire            pull_n  = (opr == OP_WR && (md != SZ_B || !cnt[0])) || (opr == OP_CK && !cnt[0]);
  wire            push_n  = md != SZ_B || cnt[0] || (cnt + CW'(1) == len);

  assign xl_req     = st == S_XLAT;
  assign xl_vpn     = cur_va[VA_W-1:PB];
  assign mem_req    = st == S_MEM;
  assign mem_we     = opr == OP_WR;
  assign mem_size   = md;
  assign mem_addr   = pa;
  assign mem_wdata  = (md == SZ_L) ? stg : (md == SZ_W) ? {16'h0, stg[15:0]} : {24'h0, sbyte};
  assign din_ready  = st == S_PULL;
  assign dout_valid = st == S_PUSH;
  assign dout_data  = hw ? stg[31:16] : stg[15:0];
  assign done       = st == S_FIN;
  assign nbytes     = cnt;
  assign va_o       = cur_va;
  assign bc_o       = bc0 + BC_W'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  opr <= OP_RD;  md <= SZ_B;
      len <= '0;  cnt <= '0;  va0 <= '0;  bc0 <= '0;
      left <= '0;  pa <= '0;  stg <= '0;  hw <= 1'b0;
      err_inval <= 1'b0;  err_rdto <= 1'b0;  err_wcl <= 1'b0;  err_wch <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          opr <= op;  va0 <= va_i;  bc0 <= bc_i;  len <= len_n;  cnt <= '0;
          err_inval <= 1'b0;  err_rdto <= 1'b0;  err_wcl <= 1'b0;  err_wch <= 1'b0;
          st <= (len_n == '0) ? S_FIN : S_XLAT;
        end
        S_XLAT: if (xl_ack) begin
          if (!xl_valid) begin
            err_inval <= 1'b1;  st <= S_FIN;
          end else if (xl_nxm) begin
            err_rdto <= 1'b1;  st <= S_FIN;
          end else begin
            pa <= {xl_pfn, off};  left <= clen;  md <= sel;  st <= S_ACC;
          end
        end
        S_ACC: begin
          hw <= 1'b0;
          st <= pull_n ? S_PULL : S_MEM;
        end
        S_PULL: if (din_valid) begin
          if (md == SZ_L && !hw) begin
            stg[15:0] <= din_data;  hw <= 1'b1;
          end else begin
            if (md == SZ_L) stg[31:16] <= din_data;
            else            stg[15:0]  <= din_data;
            hw <= 1'b0;  st <= S_MEM;
          end
        end
        S_MEM: if (mem_ack) begin
          if (opr == OP_CK && miss) begin
            err_wch <= cnt[0];  err_wcl <= !cnt[0];  st <= S_FIN;
          end else begin
            if (opr == OP_RD) begin
              case (md)
                SZ_L:    stg <= mem_rdata;
                SZ_W:    stg[15:0] <= mem_rdata[15:0];
                default: if (cnt[0]) stg[15:8] <= mem_rdata[7:0];
                         else        stg[15:0] <= {8'h0, mem_rdata[7:0]};
              endcase
            end
            cnt  <= cnt + CW'(asz);
            pa   <= pa + PA_W'(asz);
            left <= left - LW'(asz);
            hw   <= 1'b0;
            st   <= (opr == OP_RD && push_n) ? S_PUSH : S_NEXT;
          end
        end
        S_PUSH: if (dout_ready) begin
          if (md == SZ_L && !hw) hw <= 1'b1;
          else begin
            hw <= 1'b0;  st <= S_NEXT;
          end
        end
        S_NEXT: st <= (cnt == len) ? S_FIN : (left == '0) ? S_XLAT : S_ACC;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> nbytes <= len); // R1
  AST_XL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (xl_req && !xl_ack) |=> (xl_req && $stable(xl_vpn))); // R2
  AST_LONG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_size == SZ_L) |-> mem_addr[1:0] == 2'b00); // R3
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_size == SZ_W) |-> !mem_addr[0]); // R4
  AST_CHECK_BYTES: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && opr == OP_CK) |-> (mem_size == SZ_B && !mem_we)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_size))); // R11
endmodule

// File: tb/sim_pgdma_engine.sv
`timescale 1ns/1ps
module sim_pgdma_engine;
  localparam int PB = 4, VA_W = 17, BC_W = 16, PFN_W = 8;
  localparam int PA_W = PFN_W + PB;
  localparam int MSZ = 1 << PA_W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [BC_W:0] req_len = '0;
  logic [VA_W-1:0] va_i = '0;
  logic [BC_W-1:0] bc_i = '0;
  logic xl_req, xl_ack = 1'b0, xl_valid = 1'b0, xl_nxm = 1'b0;
  logic [VA_W-PB-1:0] xl_vpn;
  logic [PFN_W-1:0] xl_pfn = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [1:0] mem_size;
  logic [PA_W-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [15:0] din_data = '0, dout_data;
  logic din_valid = 1'b0, din_ready, dout_valid, dout_ready = 1'b0;
  logic done, err_inval, err_rdto, err_wcl, err_wch;
  logic [BC_W:0] nbytes;
  logic [VA_W-1:0] va_o;
  logic [BC_W-1:0] bc_o;

  pgdma_engine #(.PB(PB), .VA_W(VA_W), .BC_W(BC_W), .PFN_W(PFN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .req_len(req_len), .va_i(va_i), .bc_i(bc_i),
    .xl_req(xl_req), .xl_vpn(xl_vpn), .xl_ack(xl_ack), .xl_valid(xl_valid), .xl_nxm(xl_nxm), .xl_pfn(xl_pfn),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .din_data(din_data), .din_valid(din_valid), .din_ready(din_ready),
    .dout_data(dout_data), .dout_valid(dout_valid), .dout_ready(dout_ready), .done(done), .nbytes(nbytes),
    .va_o(va_o), .bc_o(bc_o), .err_inval(err_inval), .err_rdto(err_rdto), .err_wcl(err_wcl), .err_wch(err_wch));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int bad_vpn = -1, nxm_vpn = -1;
  int szc [0:2];
  int xlc = 0;
  logic [7:0] mem [0:MSZ-1];
  logic [7:0] snap [0:MSZ-1];
  logic [15:0] exp_q [$];
  logic [15:0] src_q [$];
  logic took = 1'b0, dtook = 1'b0;
  logic [15:0] dcap = '0;

  function automatic int pfn_of(int vpn);
    return (vpn * 5 + 3) & 255;
  endfunction
  function automatic int pa_of(int v);
    int w = v & 'h1FFFF;
    return (pfn_of(w >> 4) << 4) | (w & 15);
  endfunction
  function automatic logic [15:0] sw(int j);
    return 16'hC3A5 ^ 16'(j * 16'h0457);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    took <= din_valid && din_ready;
    dtook <= dout_valid && dout_ready;
    dcap <= dout_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      szc[mem_size] = szc[mem_size] + 1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata[7:0];
        if (mem_size != 2'd0) mem[mem_addr + 1] = mem_wdata[15:8];
        if (mem_size == 2'd2) begin
          mem[mem_addr + 2] = mem_wdata[23:16];
          mem[mem_addr + 3] = mem_wdata[31:24];
        end
      end else begin
        mem_rdata <= {mem[mem_addr + 3], mem[mem_addr + 2], mem[mem_addr + 1], mem[mem_addr]};
      end
    end else mem_ack <= 1'b0;
    if (xl_req && !xl_ack) begin
      xl_ack <= 1'b1;
      xlc = xlc + 1;
      xl_pfn <= PFN_W'(pfn_of(int'(xl_vpn)));
      xl_valid <= int'(xl_vpn) != bad_vpn;
      xl_nxm <= int'(xl_vpn) == nxm_vpn;
    end else xl_ack <= 1'b0;
  end

  // scoreboard monitor and drive-side source
  always @(negedge clk) begin
    if (took && src_q.size() > 0) void'(src_q.pop_front());
    din_valid = (src_q.size() > 0) && (cyc % 5 != 2);
    din_data = (src_q.size() > 0) ? src_q[0] : 16'h0;
    dout_ready = (cyc % 3 != 1);
    if (dtook) begin
      if (exp_q.size() == 0) chk("R5 unexpected word", int'(dcap), -1);
      else chk("R5 stream word", int'(dcap), int'(exp_q.pop_front()));
    end
  end

  task automatic run(string name, int opc, int va, int bc, int req, int mm);
    int len, dn, kind, xlt, w, mism;
    int ea [0:2];
    logic [7:0] expm [0:MSZ-1];
    len = 65536 - bc;
    if (req < len) len = req;
    dn = len; kind = 0; xlt = 0;
    for (int k = 0; k < len; k++) begin
      int v = (va + k) & 'h1FFFF;
      if (k == 0 || (v & 15) == 0) begin
        xlt++;
        if ((v >> 4) == bad_vpn) begin kind = 1; dn = k; break; end
        if ((v >> 4) == nxm_vpn) begin kind = 2; dn = k; break; end
      end
      if (opc == 2 && k == mm) begin kind = (k % 2 == 0) ? 3 : 4; dn = k; break; end
    end
    for (int m = 0; m < 3; m++) begin ea[m] = 0; szc[m] = 0; end
    xlc = 0;
    begin
      int k = 0;
      while (k < dn) begin
        int v = (va + k) & 'h1FFFF;
        int cl = 16 - (v & 15);
        int p = pa_of(v);
        int m;
        if (len - k < cl) cl = len - k;
        m = (((p | cl | k) & 1) != 0) ? 0 : (((p | cl) & 2) != 0) ? 1 : 2;
        ea[m] += cl / (1 << m);
        k += cl;
      end
    end
    for (int a = 0; a < MSZ; a++) begin snap[a] = mem[a]; expm[a] = mem[a]; end
    if (opc == 0) begin
      int nw = dn / 2 + ((dn == len && (len % 2) == 1) ? 1 : 0);
      for (int j = 0; j < nw; j++) begin
        logic [7:0] lo = mem[pa_of(va + 2 * j)];
        logic [7:0] hi = (2 * j + 1 < dn) ? mem[pa_of(va + 2 * j + 1)] : 8'h00;
        exp_q.push_back({hi, lo});
      end
    end else if (opc == 1) begin
      for (int j = 0; j < (len + 1) / 2; j++) src_q.push_back(sw(j));
      for (int k = 0; k < dn; k++) begin
        logic [15:0] s = sw(k / 2);
        expm[pa_of(va + k)] = (k % 2 == 0) ? s[7:0] : s[15:8];
      end
    end else begin
      for (int j = 0; j < (len + 1) / 2; j++) begin
        logic [7:0] lo = mem[pa_of(va + 2 * j)];
        logic [7:0] hi = (2 * j + 1 < len) ? mem[pa_of(va + 2 * j + 1)] : 8'h00;
        if (mm == 2 * j) lo = lo ^ 8'hFF;
        if (mm == 2 * j + 1) hi = hi ^ 8'hFF;
        src_q.push_back({hi, lo});
      end
    end
    @(negedge clk);
    op = 2'(opc); va_i = VA_W'(va); bc_i = BC_W'(bc); req_len = (BC_W + 1)'(req); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    if (w >= 5000) chk({name, " watchdog"}, 0, 1);
    chk({name, " R10 nbytes"}, int'(nbytes), dn);
    chk({name, " R9 va_o"}, int'(va_o), (va + dn) & 'h1FFFF);
    chk({name, " R9 bc_o"}, int'(bc_o), (bc + dn) & 'hFFFF);
    chk({name, " R7 err_inval"}, int'(err_inval), int'(kind == 1));
    chk({name, " R7 err_rdto"}, int'(err_rdto), int'(kind == 2));
    chk({name, " R8 err_wcl"}, int'(err_wcl), int'(kind == 3));
    chk({name, " R8 err_wch"}, int'(err_wch), int'(kind == 4));
    @(negedge clk);
    chk({name, " R10 single pulse"}, int'(done), 0);
    repeat (12) @(negedge clk);
    chk({name, " R2 translations"}, xlc, xlt);
    if (opc == 0) chk({name, " R5 words outstanding"}, exp_q.size(), 0);
    if (opc != 2) begin
      chk({name, " R3 longword accesses"}, szc[2], ea[2]);
      chk({name, " R4 word accesses"}, szc[1], ea[1]);
      chk({name, " R4 byte accesses"}, szc[0], ea[0]);
    end
    mism = 0;
    for (int a = 0; a < MSZ; a++) if (mem[a] !== expm[a]) mism++;
    chk({name, " R6 memory image"}, mism, 0);
    src_q.delete();
    exp_q.delete();
  endtask

  initial begin
    for (int a = 0; a < MSZ; a++) mem[a] = 8'((a * 7 + 1) & 255);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset mem_req", int'(mem_req), 0);
    chk("R11 reset xl_req", int'(xl_req), 0);
    chk("R11 reset dout_valid", int'(dout_valid), 0);
    chk("R11 reset din_ready", int'(din_ready), 0);
    run("read aligned R3", 0, 'h20, 0, 32, -1);
    run("read odd address R4", 0, 'h13, 0, 10, -1);
    run("read word R4", 0, 'h22, 0, 12, -1);
    run("read odd across pages R5", 0, 'h1D, 0, 9, -1);
    run("write across pages R6", 1, 'h3C, 0, 24, -1);
    run("write odd length R6", 1, 'h51, 0, 7, -1);
    run("count limit R1", 0, 'h40, 'hFFF8, 100, -1);
    run("address wrap R9", 1, 'h1FFF8, 'h1234, 16, -1);
    run("zero length R1", 0, 'h60, 0, 0, -1);
    bad_vpn = 'h12;
    run("invalid page R7", 0, 'h100, 0, 48, -1);
    bad_vpn = -1; nxm_vpn = 'h21;
    run("nonexistent page R7", 1, 'h200, 0, 40, -1);
    nxm_vpn = -1;
    run("check match R8", 2, 'h300, 0, 20, -1);
    run("check even miss R8", 2, 'h305, 0, 20, 6);
    run("check odd miss R8", 2, 'h30A, 0, 20, 9);
    run("read after error R10", 0, 'h400, 0, 8, -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule